// File: doc/BRIEF.md
# PLL Power Sequencer

This block takes over the bring-up and shut-down of an analog PLL macro from software. It drives three control lines toward the PLL in a fixed order: bypass release, the active-low reset release and the output enable. Between them it inserts the microsecond gaps the macro needs, measured by counting pulses of a one-microsecond tick input. On the way up it waits for the lock-detect input before the output is enabled. If lock never arrives, the sequencer gives up after a bounded number of tick polls and raises a sticky error.

A strap input selects a shared-vote mode. In that mode the direct sequence is never run. An enable request only raises a vote line and waits for the PLL's active flag. A disable request only drops the vote. A 32-bit mode word packs the three control lines, the strap and the two PLL status inputs at fixed positions, so a neighbouring register file can expose it.

Top module: `pll_pwr_seq`

## Requirements
- R1: After synchronous reset, out_en, byp_rel, rst_rel, vote_out, busy, done and seq_err are all 0.
- R2: mode_word bit 0 is out_en, bit 1 is byp_rel, bit 2 is rst_rel, bit 20 is vote_strap, bit 30 is active_in and bit 31 is lock_in. Every other bit is 0.
- R3: A direct enable accepted in idle sets byp_rel at the accepting edge. rst_rel rises at the edge that samples the GAP_UP_US-th tick after that.
- R4: While waiting for lock, the edge that samples lock_in high sets out_en, pulses done for one cycle and returns to idle.
- R5: An enable request in idle when out_en, byp_rel and rst_rel are all 1 changes no control line, keeps busy low and pulses done one cycle later.
- R6: A direct disable clears out_en at the accepting edge. It then clears rst_rel and byp_rel together, with a done pulse, at the edge that samples the GAP_DN_US-th tick after that.
- R7: With vote_strap at 1, an enable sets only vote_out. The edge that samples active_in high pulses done and returns to idle.
- R8: With vote_strap at 1, a disable clears vote_out and pulses done at the accepting edge, and busy stays low.
- R9: If the awaited flag (lock_in, or active_in in vote mode) is still low at the POLL_MAX-th tick of the wait, seq_err sets and stays set until reset. done pulses, the sequencer returns to idle and out_en stays 0.
- R10: Enable and disable requests that arrive while busy is 1 are ignored.
- R11: When en_req and dis_req are both high in idle, the disable is taken.
- R12: busy is 1 exactly while a sequence is in progress, and busy is 0 in any cycle where done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Power-up request, sampled when idle |
| dis_req | input | 1 | Power-down request, sampled when idle |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| lock_in | input | 1 | Lock detect from the PLL |
| active_in | input | 1 | Active flag from the PLL (vote mode) |
| vote_strap | input | 1 | Selects vote mode |
| out_en | output | 1 | PLL output enable |
| byp_rel | output | 1 | Bypass release |
| rst_rel | output | 1 | Reset release (drives the active-low reset high) |
| vote_out | output | 1 | Vote line in vote mode |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| seq_err | output | 1 | Sticky timeout flag |
| mode_word | output | 32 | Packed control and status word |

## Verification
Every control output, busy, done and seq_err is a register. Each is therefore due at the first clock edge that samples the deciding input: the request, the N-th tick or the high flag. The bench's behavioural model advances at that same edge.

mode_word follows its status inputs combinationally, so it changes within the cycle in which an input changes. Inputs are driven just after the falling edge, and all outputs are compared against the model on every falling edge. This puts each sample half a cycle after the edge that must have produced it. Directed checks after each scenario confirm the settled state.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_UP_GAP    = 3'd1,
        S_UP_LOCK   = 3'd2,
        S_DN_GAP    = 3'd3,
        S_VOTE_WAIT = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic rst_rel;
        logic byp_rel;
        logic out_en;
    } ctl_bits_t;

    localparam int unsigned MW_OUT_EN  = 0;
    localparam int unsigned MW_BYP     = 1;
    localparam int unsigned MW_RST     = 2;
    localparam int unsigned MW_VOTE    = 20;
    localparam int unsigned MW_ACTIVE  = 30;
    localparam int unsigned MW_LOCK    = 31;
    localparam int unsigned MW_WIDTH   = 32;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic ctl_all_on(input ctl_bits_t c);
        return c.out_en & c.byp_rel & c.rst_rel;
    endfunction

endpackage

// File: rtl/pll_seq_tick_timer.sv
module pll_seq_tick_timer #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // expires on the limit-th tick since the last clear
    assign expire = tick && (cnt_q == (limit - 1'b1));

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int unsigned CW        = 7,
    parameter int unsigned GAP_UP_US = 5,
    parameter int unsigned GAP_DN_US = 1,
    parameter int unsigned POLL_MAX  = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_req,
    input  logic          dis_req,
    input  logic          vote_mode,
    input  logic          lock_in,
    input  logic          active_in,
    input  logic          expire,
    output logic          tmr_clr,
    output logic [CW-1:0] tmr_limit,
    output ctl_bits_t     ctl,
    output logic          vote_out,
    output logic          busy,
    output logic          done,
    output logic          seq_err
);
    localparam logic [CW-1:0] LIM_UP   = CW'(GAP_UP_US);
    localparam logic [CW-1:0] LIM_DN   = CW'(GAP_DN_US);
    localparam logic [CW-1:0] LIM_POLL = CW'(POLL_MAX);

    seq_state_e state_q, state_d;
    ctl_bits_t  ctl_q, ctl_d;
    logic       vote_q, vote_d;
    logic       done_q, done_d;
    logic       err_q, err_d;

    always_comb begin
        state_d = state_q;
        ctl_d   = ctl_q;
        vote_d  = vote_q;
        done_d  = 1'b0;
        err_d   = err_q;
        unique case (state_q)
            S_IDLE: begin
                if (dis_req) begin
                    if (vote_mode) begin
                        vote_d = 1'b0;
                        done_d = 1'b1;
                    end else begin
                        ctl_d.out_en = 1'b0;
                        state_d      = S_DN_GAP;
                    end
                end else if (en_req) begin
                    if (vote_mode) begin
                        vote_d  = 1'b1;
                        state_d = S_VOTE_WAIT;
                    end else if (ctl_all_on(ctl_q)) begin
                        done_d = 1'b1;
                    end else begin
                        ctl_d.byp_rel = 1'b1;
                        state_d       = S_UP_GAP;
                    end
                end
            end
            S_UP_GAP: begin
                if (expire) begin
                    ctl_d.rst_rel = 1'b1;
                    state_d       = S_UP_LOCK;
                end
            end
            S_UP_LOCK: begin
                if (lock_in) begin
                    ctl_d.out_en = 1'b1;
                    done_d       = 1'b1;
                    state_d      = S_IDLE;
                end else if (expire) begin
                    err_d   = 1'b1;
                    done_d  = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_DN_GAP: begin
                if (expire) begin
                    ctl_d.byp_rel = 1'b0;
                    ctl_d.rst_rel = 1'b0;
                    done_d        = 1'b1;
                    state_d       = S_IDLE;
                end
            end
            S_VOTE_WAIT: begin
                if (active_in) begin
                    done_d  = 1'b1;
                    state_d = S_IDLE;
                end else if (expire) begin
                    err_d   = 1'b1;
                    done_d  = 1'b1;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            ctl_q   <= '0;
            vote_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
            vote_q  <= vote_d;
            done_q  <= done_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        unique case (state_q)
            S_UP_GAP: tmr_limit = LIM_UP;
            S_DN_GAP: tmr_limit = LIM_DN;
            default:  tmr_limit = LIM_POLL;
        endcase
    end

    assign tmr_clr  = (state_q == S_IDLE) || (state_d != state_q);
    assign ctl      = ctl_q;
    assign vote_out = vote_q;
    assign busy     = (state_q != S_IDLE);
    assign done     = done_q;
    assign seq_err  = err_q;

endmodule

// File: rtl/pll_seq_mode_word.sv
module pll_seq_mode_word
    import pll_seq_pkg::*;
(
    input  ctl_bits_t             ctl,
    input  logic                  vote_strap,
    input  logic                  active_in,
    input  logic                  lock_in,
    output logic [MW_WIDTH-1:0]   word
);
    always_comb begin
        word            = '0;
        word[MW_OUT_EN] = ctl.out_en;
        word[MW_BYP]    = ctl.byp_rel;
        word[MW_RST]    = ctl.rst_rel;
        word[MW_VOTE]   = vote_strap;
        word[MW_ACTIVE] = active_in;
        word[MW_LOCK]   = lock_in;
    end
endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
    import pll_seq_pkg::*;
#(
    parameter int unsigned GAP_UP_US = 5,
    parameter int unsigned GAP_DN_US = 1,
    parameter int unsigned POLL_MAX  = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_req,
    input  logic        dis_req,
    input  logic        us_tick,
    input  logic        lock_in,
    input  logic        active_in,
    input  logic        vote_strap,
    output logic        out_en,
    output logic        byp_rel,
    output logic        rst_rel,
    output logic        vote_out,
    output logic        busy,
    output logic        done,
    output logic        seq_err,
    output logic [31:0] mode_word
);
    localparam int unsigned LIM_MAX = max3(GAP_UP_US, GAP_DN_US, POLL_MAX);
    localparam int unsigned CW      = $clog2(LIM_MAX + 1);

    logic          tmr_clr;
    logic          expire;
    logic [CW-1:0] tmr_limit;
    ctl_bits_t     ctl;

    pll_seq_tick_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (tmr_clr),
        .tick   (us_tick),
        .limit  (tmr_limit),
        .expire (expire)
    );

    pll_seq_fsm #(
        .CW        (CW),
        .GAP_UP_US (GAP_UP_US),
        .GAP_DN_US (GAP_DN_US),
        .POLL_MAX  (POLL_MAX)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en_req    (en_req),
        .dis_req   (dis_req),
        .vote_mode (vote_strap),
        .lock_in   (lock_in),
        .active_in (active_in),
        .expire    (expire),
        .tmr_clr   (tmr_clr),
        .tmr_limit (tmr_limit),
        .ctl       (ctl),
        .vote_out  (vote_out),
        .busy      (busy),
        .done      (done),
        .seq_err   (seq_err)
    );

    pll_seq_mode_word u_word (
        .ctl        (ctl),
        .vote_strap (vote_strap),
        .active_in  (active_in),
        .lock_in    (lock_in),
        .word       (mode_word)
    );

    assign out_en  = ctl.out_en;
    assign byp_rel = ctl.byp_rel;
    assign rst_rel = ctl.rst_rel;

endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk (
    input logic clk,
    input logic rst,
    input logic lock_in,
    input logic out_en,
    input logic byp_rel,
    input logic rst_rel,
    input logic vote_out,
    input logic busy,
    input logic done,
    input logic seq_err
);
    // R4: output enable only follows a sampled lock
    a_r4_oe_after_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(out_en) |-> $past(lock_in));

    // R3: reset release only while bypass was already released
    a_r3_reset_after_bypass: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_rel) |-> (byp_rel && $past(byp_rel)));

    // R6: bypass drops only after output enable was already off
    a_r6_oe_off_first: assert property (@(posedge clk) disable iff (rst)
        $fell(byp_rel) |-> (!out_en && !$past(out_en)));

    // R6: reset and bypass clear together
    a_r6_clear_together: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_rel) |-> $fell(byp_rel));

    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

    // R12: done never overlaps busy
    a_r12_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: raising the vote touches no direct control line
    a_r7_vote_only: assert property (@(posedge clk) disable iff (rst)
        $rose(vote_out) |-> ($stable(out_en) && $stable(byp_rel) && $stable(rst_rel)));
endmodule

bind pll_pwr_seq pll_pwr_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .lock_in  (lock_in),
    .out_en   (out_en),
    .byp_rel  (byp_rel),
    .rst_rel  (rst_rel),
    .vote_out (vote_out),
    .busy     (busy),
    .done     (done),
    .seq_err  (seq_err)
);

// File: tb/tb_pll_pwr_seq.sv
module tb_pll_pwr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int GAP_UP     = 5;
    localparam int GAP_DN     = 1;
    localparam int POLL       = 100;
    localparam int TICK_DIV   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_req = 1'b0, dis_req = 1'b0, us_tick = 1'b0;
    logic lock_in = 1'b0, active_in = 1'b0, vote_strap = 1'b0;
    logic out_en, byp_rel, rst_rel, vote_out, busy, done, seq_err;
    logic [31:0] mode_word;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit lock_on  = 1'b1;
    bit act_on   = 1'b1;
    int tick_cnt = 0;
    int lk_cnt   = 0;
    int ac_cnt   = 0;

    // reference model state
    int m_st = 0;   // 0 idle 1 gap-up 2 lock-wait 3 gap-down 4 vote-wait
    int m_t  = 0;
    bit m_oe, m_byp, m_rr, m_vote, m_done, m_err;

    pll_pwr_seq #(.GAP_UP_US(GAP_UP), .GAP_DN_US(GAP_DN), .POLL_MAX(POLL)) dut (
        .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .us_tick(us_tick),
        .lock_in(lock_in), .active_in(active_in), .vote_strap(vote_strap),
        .out_en(out_en), .byp_rel(byp_rel), .rst_rel(rst_rel), .vote_out(vote_out),
        .busy(busy), .done(done), .seq_err(seq_err), .mode_word(mode_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // environment: tick, lock and active models, driven just after the falling edge
    always @(negedge clk) begin
        #1;
        tick_cnt = tick_cnt + 1;
        us_tick  = (tick_cnt % TICK_DIV) == 0;
        if (lock_on && rst_rel) lk_cnt = lk_cnt + 1; else lk_cnt = 0;
        lock_in = (lk_cnt >= 8);
        if (act_on && vote_out) ac_cnt = ac_cnt + 1; else ac_cnt = 0;
        active_in = (ac_cnt >= 6);
    end

    // behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        m_done = 1'b0;
        if (rst) begin
            m_st = 0; m_t = 0; m_oe = 0; m_byp = 0; m_rr = 0; m_vote = 0; m_err = 0;
        end else begin
            case (m_st)
                0: if (dis_req) begin
                       if (vote_strap) begin m_vote = 0; m_done = 1; end
                       else begin m_oe = 0; m_st = 3; m_t = 0; end
                   end else if (en_req) begin
                       if (vote_strap) begin m_vote = 1; m_st = 4; m_t = 0; end
                       else if (m_oe && m_byp && m_rr) m_done = 1;
                       else begin m_byp = 1; m_st = 1; m_t = 0; end
                   end
                1: if (us_tick) begin
                       m_t = m_t + 1;
                       if (m_t == GAP_UP) begin m_rr = 1; m_st = 2; m_t = 0; end
                   end
                2: if (lock_in) begin m_oe = 1; m_done = 1; m_st = 0; end
                   else if (us_tick) begin
                       m_t = m_t + 1;
                       if (m_t == POLL) begin m_err = 1; m_done = 1; m_st = 0; end
                   end
                3: if (us_tick) begin
                       m_t = m_t + 1;
                       if (m_t == GAP_DN) begin m_byp = 0; m_rr = 0; m_done = 1; m_st = 0; end
                   end
                4: if (active_in) begin m_done = 1; m_st = 0; end
                   else if (us_tick) begin
                       m_t = m_t + 1;
                       if (m_t == POLL) begin m_err = 1; m_done = 1; m_st = 0; end
                   end
                default: m_st = 0;
            endcase
        end
        if (cyc == 150000) begin
            n_fails++;
            $display("FAIL R12 watchdog expired actual=busy expected=idle");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 out_en", {31'd0, out_en}, {31'd0, m_oe});
            chk("R3 byp_rel", {31'd0, byp_rel}, {31'd0, m_byp});
            chk("R6 rst_rel", {31'd0, rst_rel}, {31'd0, m_rr});
            chk("R7 vote_out", {31'd0, vote_out}, {31'd0, m_vote});
            chk("R12 busy", {31'd0, busy}, {31'd0, (m_st != 0)});
            chk("R5 done", {31'd0, done}, {31'd0, m_done});
            chk("R9 seq_err", {31'd0, seq_err}, {31'd0, m_err});
            chk("R2 mode_word", mode_word,
                {lock_in, active_in, 9'd0, vote_strap, 17'd0, m_rr, m_byp, m_oe});
        end
    end

    task automatic req(input bit e, input bit d);
        @(negedge clk); #1; en_req = e; dis_req = d;
        @(negedge clk); #1; en_req = 1'b0; dis_req = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset out_en", {31'd0, out_en}, 32'd0);
        chk("R1 reset ctl", {29'd0, rst_rel, byp_rel, vote_out}, 32'd0);
        chk("R1 reset status", {29'd0, busy, done, seq_err}, 32'd0);
        #1 rst = 1'b0;

        // R3/R4: direct power-up
        req(1, 0);
        wait_idle();
        chk("R4 powered up", {31'd0, out_en}, 32'd1);
        chk("R2 word up", mode_word, 32'h8000_0007);

        // R5: enable when already on
        req(1, 0);
        chk("R5 no busy", {31'd0, busy}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R5 unchanged", mode_word, 32'h8000_0007);

        // R6: power-down
        req(0, 1);
        wait_idle();
        chk("R6 all off", {29'd0, rst_rel, byp_rel, out_en}, 32'd0);

        // R10: disable while busy is ignored
        req(1, 0);
        repeat (3) @(negedge clk);
        req(0, 1);
        wait_idle();
        chk("R10 disable ignored", {31'd0, out_en}, 32'd1);
        req(0, 1);
        wait_idle();

        // R9: lock never arrives
        lock_on = 1'b0;
        req(1, 0);
        wait_idle();
        chk("R9 timeout err", {31'd0, seq_err}, 32'd1);
        chk("R9 oe low", {31'd0, out_en}, 32'd0);
        lock_on = 1'b1;

        // R11: simultaneous requests take the disable
        req(1, 1);
        wait_idle();
        chk("R11 disable won", {29'd0, rst_rel, byp_rel, out_en}, 32'd0);

        // R7/R8: vote mode
        @(negedge clk); #1 vote_strap = 1'b1;
        req(1, 0);
        wait_idle();
        chk("R7 vote up", {31'd0, vote_out}, 32'd1);
        chk("R7 word", mode_word, 32'h4010_0000);
        req(0, 1);
        chk("R8 no busy", {31'd0, busy}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R8 vote down", {31'd0, vote_out}, 32'd0);
        chk("R9 still sticky", {31'd0, seq_err}, 32'd1);
        @(negedge clk); #1 vote_strap = 1'b0;
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule